// File: doc/BRIEF.md
# Multichannel Serial Converter Lane Framer

This block turns parallel converter samples into serial bit streams. Several converter channels each deliver a 12-bit word per sample period. The block sends each word on its own one-bit lane, least significant bit first. It runs on a bit clock at twelve times the sample rate. All lanes are framed together, so a receiver can recover every channel with one shared timing reference.

Two timing outputs go with the lanes. A data clock changes level once per bit period, so each of its periods carries two bits, as a double-data-rate receiver expects. Its edges are moved half a bit period away from the lane transitions. A frame clock at the sample rate is high during the first half of each word and low during the second half. A sample arrives with a one-cycle valid strobe at any point in a word. It is kept and goes out at the next word boundary. A coding input picks offset binary (the default, unchanged) or two's complement (sign bit inverted). A power-down input stops the framer and holds every output low.

Top module: `adc_lane_serializer`

## Requirements
- R1: While `rst_n` is low, and from the first bit-clock edge that samples `pwr_down` high, every lane, `dclk_out` and `fclk_out` are 0. After reset the held sample is all zeros. After reset or power-down ends, the first word starts at bit 0.
- R2: In bit period k of a word (k = 0 to 11, counted in bit-clock cycles from the word start), each lane carries bit k of its word, so the least significant bit goes first.
- R3: Every word is 12 bit periods long. Lane i carries bits [12*i+11 : 12*i] of `samp_data`, and all lanes use the same word boundaries.
- R4: `fclk_out` is 1 during bit periods 0 to 5 of each word and 0 during bit periods 6 to 11.
- R5: `dclk_out` changes on every falling edge of `clk_bit` while running. It rises in the middle of bit period 0, so it is 1 in the second half of even bit periods and 0 in the second half of odd ones.
- R6: With `coding_twos` = 0 a word is sent unchanged (offset binary). With `coding_twos` = 1, bit 11 is inverted. The level at the word-load edge is what counts.
- R7: A strobe in the middle of a word does not disturb the word being sent. Its sample goes out in the next word. With no new strobe, the last sample is sent again.
- R8: A strobe in bit period 11 of a word is carried by the very next word.
- R9: If several strobes fall within one word, the next word carries the last of them.
- R10: Strobes that arrive during power-down are ignored. After release, the first word carries the last sample taken before power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Bit clock, twelve times the sample rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_down | input | 1 | Synchronous power-down; holds all outputs low |
| samp_valid | input | 1 | One-cycle strobe marking a new sample set |
| coding_twos | input | 1 | 0 offset binary, 1 two's complement |
| samp_data | input | 96 | Eight 12-bit samples, lane i at bits [12*i+11:12*i] |
| lane_out | output | 8 | Serial data, one bit per lane |
| dclk_out | output | 1 | Shared double-data-rate data clock |
| fclk_out | output | 1 | Shared frame clock, high in first half of word |

## Verification
The bench walks a set of sample patterns through the lanes, one pattern per word. All-zero and all-one words would hide a reversed bit order. Patterns with only the sign bit set, or all bits except the sign bit, show whether the coding control inverts exactly bit 11. Each lane receives a different word, so a crossed or shared lane shows up as a mismatch. Directed cases cover repeating a sample, a strobe in the last bit period, two strobes in one word, a strobe during power-down, and restart from both power-down and reset. The bench checks the data and frame clocks in every bit period of every word it captures.

// File: rtl/adc_ser_pkg.sv
`timescale 1ns/1ps
package adc_ser_pkg;
  localparam int unsigned LANES_DEF = 8;
  localparam int unsigned WBITS_DEF = 12;

  typedef enum logic {
    CODE_OFFSET = 1'b0,
    CODE_TWOS   = 1'b1
  } coding_e;
endpackage

// File: rtl/ser_word_timer.sv
`timescale 1ns/1ps
module ser_word_timer #(
  parameter int unsigned WBITS = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_down,
  output logic run_o,
  output logic load_o,
  output logic fclk_o
);
  localparam int unsigned CW = (WBITS > 1) ? $clog2(WBITS) : 1;
  localparam logic [CW-1:0] LAST = CW'(WBITS - 1);
  localparam logic [CW-1:0] HALF = CW'(WBITS / 2);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          run_q, run_d;
  logic          wrap;

  always_comb begin
    wrap  = (cnt_q == LAST);
    run_d = !pwr_down;
    if (pwr_down || !run_q || wrap) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  assign run_o  = run_q;
  assign load_o = !pwr_down && (!run_q || wrap);
  assign fclk_o = run_q && (cnt_q < HALF);
endmodule

// File: rtl/ser_lane.sv
`timescale 1ns/1ps
module ser_lane
  import adc_ser_pkg::*;
#(
  parameter int unsigned WBITS = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  coding_e          mode,
  input  logic [WBITS-1:0] word_i,
  output logic             bit_o
);
  logic [WBITS-1:0] sr_q, sr_d;
  logic [WBITS-1:0] coded;

  always_comb begin
    coded            = word_i;
    coded[WBITS-1]   = word_i[WBITS-1] ^ (mode == CODE_TWOS);
    if (clr) begin
      sr_d = '0;
    end else if (load) begin
      sr_d = coded;
    end else begin
      sr_d = {1'b0, sr_q[WBITS-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else begin
      sr_q <= sr_d;
    end
  end

  assign bit_o = sr_q[0];
endmodule

// File: rtl/ser_ddr_clock.sv
`timescale 1ns/1ps
module ser_ddr_clock (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic dclk_o
);
  logic dclk_q, dclk_d;

  always_comb begin
    dclk_d = run ? ~dclk_q : 1'b0;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dclk_q <= 1'b0;
    end else begin
      dclk_q <= dclk_d;
    end
  end

  assign dclk_o = dclk_q;
endmodule

// File: rtl/adc_lane_serializer.sv
`timescale 1ns/1ps
module adc_lane_serializer
  import adc_ser_pkg::*;
#(
  parameter int unsigned LANES = LANES_DEF,
  parameter int unsigned WBITS = WBITS_DEF
) (
  input  logic                   clk_bit,
  input  logic                   rst_n,
  input  logic                   pwr_down,
  input  logic                   samp_valid,
  input  logic                   coding_twos,
  input  logic [LANES*WBITS-1:0] samp_data,
  output logic [LANES-1:0]       lane_out,
  output logic                   dclk_out,
  output logic                   fclk_out
);
  localparam int unsigned BUSW = LANES * WBITS;

  logic [BUSW-1:0] hold_q, hold_d;
  logic            cap_en;
  logic            run, load;
  coding_e         mode;

  always_comb begin
    cap_en = samp_valid && !pwr_down;
    hold_d = cap_en ? samp_data : hold_q;
    mode   = coding_e'(coding_twos);
  end

  always_ff @(posedge clk_bit or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (cap_en) begin
      hold_q <= hold_d;
    end
  end

  ser_word_timer #(.WBITS(WBITS)) u_timer (
    .clk      (clk_bit),
    .rst_n    (rst_n),
    .pwr_down (pwr_down),
    .run_o    (run),
    .load_o   (load),
    .fclk_o   (fclk_out)
  );

  ser_ddr_clock u_dclk (
    .clk    (clk_bit),
    .rst_n  (rst_n),
    .run    (run),
    .dclk_o (dclk_out)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    ser_lane #(.WBITS(WBITS)) u_lane (
      .clk    (clk_bit),
      .rst_n  (rst_n),
      .clr    (pwr_down),
      .load   (load),
      .mode   (mode),
      .word_i (hold_d[g*WBITS +: WBITS]),
      .bit_o  (lane_out[g])
    );
  end
endmodule

// File: rtl/ser_checker.sv
`timescale 1ns/1ps
module ser_checker #(
  parameter int unsigned LANES = 8,
  parameter int unsigned WBITS = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pwr_down,
  input logic [LANES-1:0] lane_out,
  input logic             dclk_out,
  input logic             fclk_out
);
  localparam logic [15:0] HALF16 = 16'(WBITS / 2);

  logic [15:0] hi_cnt, lo_cnt;
  logic        f_prev, pd_prev, lo_clean;
  logic [1:0]  age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt   <= '0;
      lo_cnt   <= '0;
      f_prev   <= 1'b0;
      pd_prev  <= 1'b0;
      lo_clean <= 1'b0;
      age      <= '0;
    end else begin
      age     <= (age == 2'd3) ? age : age + 2'd1;
      f_prev  <= fclk_out;
      pd_prev <= pwr_down;
      hi_cnt  <= fclk_out ? hi_cnt + 16'd1 : 16'd0;
      lo_cnt  <= fclk_out ? 16'd0 : lo_cnt + 16'd1;
      if (pwr_down) begin
        lo_clean <= 1'b0;
      end else if (f_prev && !fclk_out && !pd_prev) begin
        lo_clean <= 1'b1;
      end
    end
  end

  // R1: outputs silent once power-down has been sampled
  assert_lanes_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pwr_down) |-> (lane_out == '0 && !fclk_out && !dclk_out));

  // R5: data clock changes every bit period while running
  assert_dclk_toggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && !$past(pwr_down) && !$past(pwr_down, 2))
      |-> (dclk_out != $past(dclk_out)));

  // R4: frame clock high phase lasts half a word
  assert_frame_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (f_prev && !fclk_out && !pd_prev) |-> (hi_cnt == HALF16));

  // R4: frame clock low phase lasts half a word
  assert_frame_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fclk_out && !f_prev && lo_clean) |-> (lo_cnt == HALF16));
endmodule

bind adc_lane_serializer ser_checker #(.LANES(LANES), .WBITS(WBITS)) u_ser_checker (
  .clk      (clk_bit),
  .rst_n    (rst_n),
  .pwr_down (pwr_down),
  .lane_out (lane_out),
  .dclk_out (dclk_out),
  .fclk_out (fclk_out)
);

// File: tb/test_adc_lane_serializer.sv
`timescale 1ns/1ps
module test_adc_lane_serializer;
  localparam int LANES = 8;
  localparam int WBITS = 12;
  localparam int NV    = 6;
  // {coding_twos, seed}
  localparam logic [12:0] VEC [NV] = '{13'h0000, 13'h0FFF, 13'h0800,
                                       13'h1800, 13'h17FF, 13'h0A5C};

  logic                   clk_bit = 1'b0;
  logic                   rst_n;
  logic                   pwr_down;
  logic                   samp_valid;
  logic                   coding_twos;
  logic [LANES*WBITS-1:0] samp_data;
  logic [LANES-1:0]       lane_out;
  logic                   dclk_out;
  logic                   fclk_out;

  int n_run  = 0;
  int n_fail = 0;
  logic [WBITS-1:0] got [LANES];
  logic [WBITS-1:0] fpat, dpat;

  always #4 clk_bit = ~clk_bit;

  adc_lane_serializer i_adc_lane_serializer (
    .clk_bit(clk_bit), .rst_n(rst_n), .pwr_down(pwr_down),
    .samp_valid(samp_valid), .coding_twos(coding_twos), .samp_data(samp_data),
    .lane_out(lane_out), .dclk_out(dclk_out), .fclk_out(fclk_out));

  function automatic logic [WBITS-1:0] lane_word(input logic [WBITS-1:0] seed, input int i);
    return seed ^ WBITS'(i * 585);
  endfunction

  function automatic logic [WBITS-1:0] frame_exp();
    logic [WBITS-1:0] r;
    for (int k = 0; k < WBITS; k++) r[k] = (k < WBITS / 2);
    return r;
  endfunction

  function automatic logic [WBITS-1:0] dclk_exp();
    logic [WBITS-1:0] r;
    for (int k = 0; k < WBITS; k++) r[k] = (k % 2 == 0);
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [WBITS-1:0] act,
                       input logic [WBITS-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_sample(input logic [WBITS-1:0] seed, input logic twos);
    for (int i = 0; i < LANES; i++) samp_data[i*WBITS +: WBITS] = lane_word(seed, i);
    coding_twos = twos;
    samp_valid  = 1'b1;
  endtask

  // Called at the bit-clock edge that starts bit period 0.
  task automatic capture(input int s1, input logic [12:0] v1, input int s2, input logic [12:0] v2);
    for (int k = 0; k < WBITS; k++) begin
      #1;
      samp_valid = 1'b0;
      if (k == s1) set_sample(v1[11:0], v1[12]);
      if (k == s2) set_sample(v2[11:0], v2[12]);
      #6;
      for (int i = 0; i < LANES; i++) got[i][k] = lane_out[i];
      fpat[k] = fclk_out;
      dpat[k] = dclk_out;
      @(posedge clk_bit);
    end
  endtask

  task automatic check_word(input bit zero, input logic [12:0] v, input string req);
    for (int i = 0; i < LANES; i++) begin
      logic [WBITS-1:0] e;
      e = zero ? '0 : (lane_word(v[11:0], i) ^ {v[12], 11'b0});
      check(got[i] == e, req, got[i], e);
    end
    check(fpat == frame_exp(), "R4 frame clock pattern", fpat, frame_exp());
    check(dpat == dclk_exp(), "R5 data clock pattern", dpat, dclk_exp());
  endtask

  task automatic check_quiet(input string req);
    check(lane_out == '0, req, WBITS'(lane_out), '0);
    check({dclk_out, fclk_out} == 2'b00, req, WBITS'({dclk_out, fclk_out}), '0);
  endtask

  initial begin
    repeat (20000) @(posedge clk_bit);
    n_fail++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pwr_down = 1'b0; samp_valid = 1'b0;
    coding_twos = 1'b0; samp_data = '0;
    repeat (3) @(posedge clk_bit);
    #7 check_quiet("R1 outputs during reset");
    @(posedge clk_bit); #1 rst_n = 1'b1;
    @(posedge clk_bit);
    // R1: first word after reset carries the cleared sample
    capture(4, VEC[0], -1, '0);
    check_word(1'b1, '0, "R1 first word after reset");

    // Table walk: R2 R3 R6 R7
    for (int v = 0; v < NV; v++) begin
      int nx;
      nx = (v + 1 < NV) ? v + 1 : v;
      capture((v + 1 < NV) ? 3 + v : -1, VEC[nx], -1, '0);
      check_word(1'b0, VEC[v], "R2 R3 R6 R7 table word");
    end

    // R7: no strobe, last sample repeats
    capture(-1, '0, -1, '0);
    check_word(1'b0, VEC[NV-1], "R7 repeat without strobe");

    // R8: strobe in last bit period goes into the next word
    capture(11, 13'h1123, -1, '0);
    check_word(1'b0, VEC[NV-1], "R8 word before late strobe");
    capture(-1, '0, -1, '0);
    check_word(1'b0, 13'h1123, "R8 R6 late strobe word");

    // R9: two strobes in one word, last wins
    capture(2, 13'h03C1, 7, 13'h0E4D);
    check_word(1'b0, 13'h1123, "R9 word during double strobe");
    capture(-1, '0, -1, '0);
    check_word(1'b0, 13'h0E4D, "R9 last strobe wins");

    // R1 R10: power down mid-stream, strobe while down is ignored
    #1 pwr_down = 1'b1;
    for (int j = 0; j < 5; j++) begin
      @(posedge clk_bit);
      #1;
      samp_valid = 1'b0;
      if (j == 1) set_sample(12'h5A5, 1'b1);
      #6 check_quiet("R1 outputs during power-down");
    end
    @(posedge clk_bit);
    #1 samp_valid = 1'b0; coding_twos = 1'b0; pwr_down = 1'b0;
    @(posedge clk_bit);
    capture(-1, '0, -1, '0);
    check_word(1'b0, 13'h0E4D, "R10 R1 first word after power-down");

    // R1: asynchronous reset mid-word, then restart with cleared sample
    #3 rst_n = 1'b0;
    #1 check_quiet("R1 outputs after async reset");
    @(posedge clk_bit); #1 rst_n = 1'b1;
    @(posedge clk_bit);
    capture(-1, '0, -1, '0);
    check_word(1'b1, '0, "R1 word after mid-stream reset");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule